// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge and End-of-Interrupt Unit

This unit is the per-processor end of a prioritized interrupt controller. It tracks two sets of interrupt sources: sources that have been delivered and are waiting for the processor (the pending set) and sources the processor has taken and not yet retired (the active-service set). It also holds a 4-bit task priority threshold and drives the processor's interrupt request line. Per-source attributes come in from the source bank on flat buses, and are read here through lookups indexed by source number. Each source has a priority, a vector, a sense mode (level or edge) and an activity flag.

A delivery strobe offers a source to the pending set. The processor acknowledges with a single-cycle read strobe. One cycle later the unit answers with the winning source's vector, or with a programmable spurious vector. The processor retires work with a single-cycle end-of-interrupt strobe. When the activity flag of a source must be dropped, the unit sends the source bank a one-cycle clear pulse that carries the source index.

Top module: `cpu_irq_deliver`

## Requirements
- R1: After reset the task priority reads 0xF, the spurious vector is 0xFF, both sets are empty, and `irq_out`, `ack_vld` and `act_clr_vld` are low.
- R2: A task priority write keeps only the low 4 bits of `tpr_wdata`, and it is visible on `cur_tpr` in the next cycle. Without a write, `cur_tpr` holds its value.
- R3: A delivery of source i is accepted only if i is not already pending and its priority is strictly above the task priority. If an accepted source's priority is strictly above the pending set's best, `irq_out` is high in the next cycle, unless an acknowledge occurs in the same cycle.
- R4: The best member of a set is found by scanning upward from index 0 and replacing the candidate only on a strictly greater priority, so the lowest index wins a tie. An empty set reports priority 0.
- R5: An acknowledge with an empty pending set returns the spurious vector and issues no clear pulse.
- R6: If the pending winner's activity flag is low, or its priority is not above the task priority, the acknowledge does three things: it returns the spurious vector, it removes the winner from the pending set, and it pulses a clear for the winner.
- R7: Otherwise the acknowledge returns the winner's vector and moves the winner from the pending set to the active-service set. A clear pulse is issued when the winner is edge-sensitive (`src_level` bit = 0) and not when it is level-sensitive (bit = 1).
- R8: `ack_vld` is high in exactly the cycle after `ack_rd`, with `ack_vector` valid in that cycle. `irq_out` is low in the cycle after an acknowledge. One cycle later it goes high again if the best pending priority is strictly above the best active-service priority.
- R9: An end-of-interrupt removes the best member of the active-service set and does nothing if that set is empty. One cycle later `irq_out` is set if the best pending priority is strictly above the remaining active-service best. An end-of-interrupt never clears `irq_out`.
- R10: A spurious vector write stores all 8 bits of `spur_wdata`, and later spurious answers return that value.
- R11: `act_clr_vld` is a pulse one cycle long, issued only in the cycle after an acknowledge, with `act_clr_idx` giving the source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_prio | input | NUM_SRC*PRIO_W | Priority of each source, source i at bits [i*PRIO_W +: PRIO_W] |
| src_vec | input | NUM_SRC*VEC_W | Vector of each source, source i at bits [i*VEC_W +: VEC_W] |
| src_level | input | NUM_SRC | Sense mode per source, 1 = level, 0 = edge |
| src_active | input | NUM_SRC | Activity flag per source |
| raise_vld | input | 1 | Offer a source to the pending set |
| raise_idx | input | IDX_W | Source index offered |
| tpr_wr | input | 1 | Task priority write strobe |
| tpr_wdata | input | VEC_W | Task priority write data; low 4 bits kept |
| cur_tpr | output | TPR_W | Current task priority |
| spur_wr | input | 1 | Spurious vector write strobe |
| spur_wdata | input | VEC_W | Spurious vector write data |
| ack_rd | input | 1 | Acknowledge read strobe, single cycle |
| ack_vld | output | 1 | Acknowledge answer valid |
| ack_vector | output | VEC_W | Acknowledge answer |
| eoi_wr | input | 1 | End-of-interrupt strobe, single cycle, never together with `ack_rd` |
| irq_out | output | 1 | Interrupt request to the processor |
| act_clr_vld | output | 1 | Activity-clear pulse to the source bank |
| act_clr_idx | output | IDX_W | Source whose activity flag is to be cleared |

## Verification
The embedded assertions check the following on every cycle: the request line drops after each acknowledge, every acknowledge gets an answer in the following cycle, clear pulses appear only after an acknowledge, an end-of-interrupt on a non-empty active-service set removes exactly one member, an accepted delivery that beats the pending best raises the request line, and the configuration registers hold between writes. Other behaviours can only be shown by the bench's scenarios and its reference model: which source wins a priority tie, the choice between vector and spurious answer, how level and edge sources differ in clear-pulse handling, and whether the request line comes back after an acknowledge or an end-of-interrupt depending on how the two sets compare.

// File: rtl/cpu_deliv_pkg.sv
package cpu_deliv_pkg;

  // Outcome of an acknowledge strobe in the current cycle
  typedef enum logic [1:0] {
    ACK_NONE  = 2'd0,
    ACK_EMPTY = 2'd1,
    ACK_SPUR  = 2'd2,
    ACK_TAKE  = 2'd3
  } ack_kind_e;

endpackage

// File: rtl/cpu_deliv_rst_sync.sv
module cpu_deliv_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/cpu_deliv_pick.sv
// Upward scan: first member found, then replaced only on a strictly higher priority.
module cpu_deliv_pick #(
  parameter int N  = 16,
  parameter int PW = 5,
  parameter int IW = 4
) (
  input  logic [N-1:0]    members,
  input  logic [N*PW-1:0] prio_flat,
  output logic            found,
  output logic [IW-1:0]   win_idx,
  output logic [PW-1:0]   win_prio
);

  always_comb begin
    found    = 1'b0;
    win_idx  = '0;
    win_prio = '0;
    for (int i = 0; i < N; i++) begin
      if (members[i] && (!found || (prio_flat[i*PW +: PW] > win_prio))) begin
        found    = 1'b1;
        win_idx  = IW'(i);
        win_prio = prio_flat[i*PW +: PW];
      end
    end
  end

endmodule

// File: rtl/cpu_deliv_cfg.sv
module cpu_deliv_cfg #(
  parameter int TPR_W = 4,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tpr_wr,
  input  logic [VEC_W-1:0] tpr_wdata,
  input  logic             spur_wr,
  input  logic [VEC_W-1:0] spur_wdata,
  output logic [TPR_W-1:0] tpr_q,
  output logic [VEC_W-1:0] spur_q
);

  localparam logic [TPR_W-1:0] TPR_RST  = '1;
  localparam logic [VEC_W-1:0] SPUR_RST = '1;

  logic [TPR_W-1:0] tpr_d;
  logic [VEC_W-1:0] spur_d;

  always_comb begin
    tpr_d  = tpr_q;
    spur_d = spur_q;
    if (tpr_wr)  tpr_d  = tpr_wdata[TPR_W-1:0];
    if (spur_wr) spur_d = spur_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tpr_q  <= TPR_RST;
      spur_q <= SPUR_RST;
    end else begin
      tpr_q  <= tpr_d;
      spur_q <= spur_d;
    end
  end

  AST_TPR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tpr_wr |=> $stable(tpr_q)); // R2

  AST_TPR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    tpr_wr |=> tpr_q == $past(tpr_wdata[TPR_W-1:0])); // R2

  AST_SPUR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !spur_wr |=> $stable(spur_q)); // R10

endmodule

// File: rtl/cpu_irq_deliver.sv
module cpu_irq_deliver
  import cpu_deliv_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int PRIO_W  = 5,
  parameter int VEC_W   = 8,
  parameter int TPR_W   = 4,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
  input  logic [NUM_SRC*VEC_W-1:0]  src_vec,
  input  logic [NUM_SRC-1:0]        src_level,
  input  logic [NUM_SRC-1:0]        src_active,
  input  logic                      raise_vld,
  input  logic [IDX_W-1:0]          raise_idx,
  input  logic                      tpr_wr,
  input  logic [VEC_W-1:0]          tpr_wdata,
  output logic [TPR_W-1:0]          cur_tpr,
  input  logic                      spur_wr,
  input  logic [VEC_W-1:0]          spur_wdata,
  input  logic                      ack_rd,
  output logic                      ack_vld,
  output logic [VEC_W-1:0]          ack_vector,
  input  logic                      eoi_wr,
  output logic                      irq_out,
  output logic                      act_clr_vld,
  output logic [IDX_W-1:0]          act_clr_idx
);

  logic rst_q_n;

  cpu_deliv_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_q_n)
  );

  // Configuration registers
  logic [TPR_W-1:0] tpr_q;
  logic [VEC_W-1:0] spur_q;

  cpu_deliv_cfg #(.TPR_W(TPR_W), .VEC_W(VEC_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .tpr_wr     (tpr_wr),
    .tpr_wdata  (tpr_wdata),
    .spur_wr    (spur_wr),
    .spur_wdata (spur_wdata),
    .tpr_q      (tpr_q),
    .spur_q     (spur_q)
  );

  assign cur_tpr = tpr_q;

  // State
  logic [NUM_SRC-1:0] raised_q, raised_d;
  logic [NUM_SRC-1:0] serv_q, serv_d;
  logic               irq_q, irq_d;
  logic               recheck_q, recheck_d;
  logic               ackv_q, ackv_d;
  logic [VEC_W-1:0]   ackd_q, ackd_d;
  logic               clrv_q, clrv_d;
  logic [IDX_W-1:0]   clri_q, clri_d;

  // Best member of each set
  logic              r_found, s_found;
  logic [IDX_W-1:0]  r_idx, s_idx;
  logic [PRIO_W-1:0] r_best, s_best;

  cpu_deliv_pick #(.N(NUM_SRC), .PW(PRIO_W), .IW(IDX_W)) u_pick_raised (
    .members   (raised_q),
    .prio_flat (src_prio),
    .found     (r_found),
    .win_idx   (r_idx),
    .win_prio  (r_best)
  );

  cpu_deliv_pick #(.N(NUM_SRC), .PW(PRIO_W), .IW(IDX_W)) u_pick_serv (
    .members   (serv_q),
    .prio_flat (src_prio),
    .found     (s_found),
    .win_idx   (s_idx),
    .win_prio  (s_best)
  );

  // Delivery acceptance
  logic [PRIO_W-1:0] tpr_ext;
  logic [PRIO_W-1:0] raise_prio;
  logic              raise_in_range;
  logic              raise_ok;
  logic              raise_hit;

  assign tpr_ext        = PRIO_W'(tpr_q);
  assign raise_prio     = src_prio[raise_idx*PRIO_W +: PRIO_W];
  assign raise_in_range = (int'(raise_idx) < NUM_SRC);
  assign raise_ok       = raise_vld && raise_in_range && !raised_q[raise_idx]
                          && (raise_prio > tpr_ext);
  assign raise_hit      = raise_ok && (raise_prio > r_best);

  // Acknowledge classification
  logic [PRIO_W-1:0] w_prio;
  logic [VEC_W-1:0]  w_vec;
  ack_kind_e         ack_kind;

  assign w_prio = src_prio[r_idx*PRIO_W +: PRIO_W];
  assign w_vec  = src_vec[r_idx*VEC_W +: VEC_W];

  always_comb begin
    ack_kind = ACK_NONE;
    if (ack_rd) begin
      if (!r_found) begin
        ack_kind = ACK_EMPTY;
      end else if (!src_active[r_idx] || (w_prio <= tpr_ext)) begin
        ack_kind = ACK_SPUR;
      end else begin
        ack_kind = ACK_TAKE;
      end
    end
  end

  // Next state
  always_comb begin
    raised_d  = raised_q;
    serv_d    = serv_q;
    irq_d     = irq_q;
    recheck_d = ack_rd || eoi_wr;
    ackv_d    = ack_rd;
    ackd_d    = ackd_q;
    clrv_d    = 1'b0;
    clri_d    = clri_q;

    case (ack_kind)
      ACK_EMPTY: begin
        ackd_d = spur_q;
      end
      ACK_SPUR: begin
        raised_d[r_idx] = 1'b0;
        ackd_d          = spur_q;
        clrv_d          = 1'b1;
        clri_d          = r_idx;
      end
      ACK_TAKE: begin
        raised_d[r_idx] = 1'b0;
        serv_d[r_idx]   = 1'b1;
        ackd_d          = w_vec;
        if (!src_level[r_idx]) begin
          clrv_d = 1'b1;
          clri_d = r_idx;
        end
      end
      default: ;
    endcase

    if (raise_ok) raised_d[raise_idx] = 1'b1;

    if (eoi_wr && s_found) serv_d[s_idx] = 1'b0;

    if (raise_hit) irq_d = 1'b1;
    if (recheck_q && (r_best > s_best)) irq_d = 1'b1;
    if (ack_rd) irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      raised_q  <= '0;
      serv_q    <= '0;
      irq_q     <= 1'b0;
      recheck_q <= 1'b0;
      ackv_q    <= 1'b0;
      ackd_q    <= '0;
      clrv_q    <= 1'b0;
      clri_q    <= '0;
    end else begin
      raised_q  <= raised_d;
      serv_q    <= serv_d;
      irq_q     <= irq_d;
      recheck_q <= recheck_d;
      ackv_q    <= ackv_d;
      ackd_q    <= ackd_d;
      clrv_q    <= clrv_d;
      clri_q    <= clri_d;
    end
  end

  assign ack_vld     = ackv_q;
  assign ack_vector  = ackd_q;
  assign irq_out     = irq_q;
  assign act_clr_vld = clrv_q;
  assign act_clr_idx = clri_q;

  // Assertions
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(ack_rd && eoi_wr)); // R8

  AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_q_n)
    ack_rd |=> !irq_out); // R8

  AST_ACK_ANSWER: assert property (@(posedge clk) disable iff (!rst_q_n)
    ack_rd |=> ack_vld); // R8

  AST_CLR_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_q_n)
    act_clr_vld |-> $past(ack_rd)); // R11

  AST_EOI_RETIRES_ONE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (eoi_wr && (serv_q != '0)) |=> ($countones(serv_q) == $countones($past(serv_q)) - 1)); // R9

  AST_RAISE_SETS_IRQ: assert property (@(posedge clk) disable iff (!rst_q_n)
    (raise_hit && !ack_rd) |=> irq_out); // R3

  AST_EOI_KEEPS_IRQ: assert property (@(posedge clk) disable iff (!rst_q_n)
    (eoi_wr && irq_out) |=> irq_out); // R9

endmodule

// File: tb/cpu_irq_deliver_test.sv
module cpu_irq_deliver_test;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 16;
  localparam int PW = 5;
  localparam int VW = 8;
  localparam int TW = 4;
  localparam int IW = $clog2(NS);

  logic clk = 1'b0;
  logic rst_n;

  logic [PW-1:0] b_prio [NS];
  logic [VW-1:0] b_vec  [NS];
  logic [NS-1:0] b_level;
  logic [NS-1:0] b_active;

  logic [NS*PW-1:0] src_prio;
  logic [NS*VW-1:0] src_vec;

  logic          raise_vld;
  logic [IW-1:0] raise_idx;
  logic          tpr_wr;
  logic [VW-1:0] tpr_wdata;
  logic [TW-1:0] cur_tpr;
  logic          spur_wr;
  logic [VW-1:0] spur_wdata;
  logic          ack_rd;
  logic          ack_vld;
  logic [VW-1:0] ack_vector;
  logic          eoi_wr;
  logic          irq_out;
  logic          act_clr_vld;
  logic [IW-1:0] act_clr_idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < NS; i++) begin
      src_prio[i*PW +: PW] = b_prio[i];
      src_vec[i*VW +: VW]  = b_vec[i];
    end
  end

  cpu_irq_deliver #(.NUM_SRC(NS), .PRIO_W(PW), .VEC_W(VW), .TPR_W(TW)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_prio    (src_prio),
    .src_vec     (src_vec),
    .src_level   (b_level),
    .src_active  (b_active),
    .raise_vld   (raise_vld),
    .raise_idx   (raise_idx),
    .tpr_wr      (tpr_wr),
    .tpr_wdata   (tpr_wdata),
    .cur_tpr     (cur_tpr),
    .spur_wr     (spur_wr),
    .spur_wdata  (spur_wdata),
    .ack_rd      (ack_rd),
    .ack_vld     (ack_vld),
    .ack_vector  (ack_vector),
    .eoi_wr      (eoi_wr),
    .irq_out     (irq_out),
    .act_clr_vld (act_clr_vld),
    .act_clr_idx (act_clr_idx)
  );

  int  total = 0;
  int  bad   = 0;
  bit  done  = 1'b0;

  // Reference model state
  bit [NS-1:0] m_raised, m_serv;
  int          m_tpr, m_spur;
  bit          m_irq, m_recheck, m_ackv, m_clrv;
  int          m_ackd, m_clri;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Upward scan, strictly greater replaces: lowest index wins ties, empty gives 0
  task automatic best_of(input bit [NS-1:0] s, output bit f, output int idx, output int pr);
    f = 1'b0; idx = 0; pr = 0;
    for (int i = 0; i < NS; i++) begin
      if (s[i] && (!f || int'(b_prio[i]) > pr)) begin
        f = 1'b1; idx = i; pr = int'(b_prio[i]);
      end
    end
  endtask

  task automatic model_step(input bit rv, input int ri, input bit ak, input bit eo,
                            input bit tw, input int td, input bit sw, input int sd);
    bit rf, sf; int ridx, rb, sidx, sb;
    bit [NS-1:0] nr, ns;
    bit nirq, hit;
    best_of(m_raised, rf, ridx, rb);
    best_of(m_serv, sf, sidx, sb);
    nr = m_raised; ns = m_serv; nirq = m_irq; hit = 1'b0;
    m_clrv = 1'b0;
    m_ackv = ak;
    if (ak) begin
      if (!rf) begin
        m_ackd = m_spur;
      end else begin
        nr[ridx] = 1'b0;
        m_clri = ridx;
        if (!b_active[ridx] || int'(b_prio[ridx]) <= m_tpr) begin
          m_ackd = m_spur; m_clrv = 1'b1;
        end else begin
          ns[ridx] = 1'b1; m_ackd = int'(b_vec[ridx]);
          if (!b_level[ridx]) m_clrv = 1'b1;
        end
      end
    end
    if (rv && !m_raised[ri] && int'(b_prio[ri]) > m_tpr) begin
      nr[ri] = 1'b1;
      if (int'(b_prio[ri]) > rb) hit = 1'b1;
    end
    if (eo && sf) ns[sidx] = 1'b0;
    if (hit) nirq = 1'b1;
    if (m_recheck && rb > sb) nirq = 1'b1;
    if (ak) nirq = 1'b0;
    m_irq = nirq;
    m_recheck = ak || eo;
    m_raised = nr; m_serv = ns;
    if (tw) m_tpr = td & 32'hF;
    if (sw) m_spur = sd & 32'hFF;
  endtask

  task automatic step(input bit rv, input int ri, input bit ak, input bit eo,
                      input bit tw, input int td, input bit sw, input int sd);
    raise_vld  = rv; raise_idx = IW'(ri);
    ack_rd     = ak; eoi_wr    = eo;
    tpr_wr     = tw; tpr_wdata = VW'(td);
    spur_wr    = sw; spur_wdata = VW'(sd);
    model_step(rv, ri, ak, eo, tw, td, sw, sd);
    @(posedge clk);
    @(negedge clk);
    raise_vld = 1'b0; ack_rd = 1'b0; eoi_wr = 1'b0; tpr_wr = 1'b0; spur_wr = 1'b0;
    chk("R3/R8/R9 irq_out", int'(irq_out), int'(m_irq));
    chk("R2 cur_tpr", int'(cur_tpr), m_tpr);
    chk("R8 ack_vld", int'(ack_vld), int'(m_ackv));
    if (m_ackv) chk("R5/R6/R7 ack_vector", int'(ack_vector), m_ackd);
    chk("R11 act_clr_vld", int'(act_clr_vld), int'(m_clrv));
    if (m_clrv) begin
      chk("R11 act_clr_idx", int'(act_clr_idx), m_clri);
      b_active[m_clri] = 1'b0;
    end
  endtask

  task automatic idle();
    step(1'b0, 0, 1'b0, 1'b0, 1'b0, 0, 1'b0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    raise_vld = 1'b0; raise_idx = '0; ack_rd = 1'b0; eoi_wr = 1'b0;
    tpr_wr = 1'b0; tpr_wdata = '0; spur_wr = 1'b0; spur_wdata = '0;
    b_level = '0; b_active = '0;
    for (int i = 0; i < NS; i++) begin
      b_prio[i] = PW'(1);
      b_vec[i]  = VW'(8'h40 + i);
    end
    m_raised = '0; m_serv = '0; m_tpr = 15; m_spur = 8'hFF;
    m_irq = 1'b0; m_recheck = 1'b0; m_ackv = 1'b0; m_clrv = 1'b0;
    m_ackd = 0; m_clri = 0;
    void'($urandom(32'h5EED_1234));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 irq_out after reset", int'(irq_out), 0);
    chk("R1 cur_tpr after reset", int'(cur_tpr), 15);
    chk("R1 ack_vld after reset", int'(ack_vld), 0);
    chk("R1 act_clr_vld after reset", int'(act_clr_vld), 0);

    // R1 / R5: empty acknowledge returns default spurious vector
    step(1'b0, 0, 1'b1, 1'b0, 1'b0, 0, 1'b0, 0);
    chk("R5 empty ack vector", int'(ack_vector), 8'hFF);
    chk("R5 empty ack no clear", int'(act_clr_vld), 0);

    // R2: write masked to low 4 bits
    step(1'b0, 0, 1'b0, 1'b0, 1'b1, 8'hA2, 1'b0, 0);
    chk("R2 tpr masked", int'(cur_tpr), 2);

    b_prio[3] = 5'd9;  b_prio[5] = 5'd9; b_prio[7] = 5'd2;
    b_prio[9] = 5'd12; b_prio[1] = 5'd20;
    b_active[3] = 1'b1; b_active[5] = 1'b1; b_active[7] = 1'b1;
    b_active[9] = 1'b1; b_active[1] = 1'b1;

    // R3: delivery above empty best raises irq
    step(1'b1, 5, 1'b0, 1'b0, 1'b0, 0, 1'b0, 0);
    chk("R3 irq after delivery", int'(irq_out), 1);
    step(1'b1, 3, 1'b0, 1'b0, 1'b0, 0, 1'b0, 0);
    step(1'b1, 7, 1'b0, 1'b0, 1'b0, 0, 1'b0, 0); // R3 rejected: priority not above tpr
    // R4: tie between 3 and 5 goes to 3; R7 edge source pulses clear
    step(1'b0, 0, 1'b1, 1'b0, 1'b0, 0, 1'b0, 0);
    chk("R4 tie lowest index", int'(ack_vector), 8'h43);
    chk("R7 edge clear idx", int'(act_clr_idx), 3);
    chk("R8 irq low after ack", int'(irq_out), 0);
    idle();
    chk("R8 no reassert when pending equals service", int'(irq_out), 0);
    chk("R11 clear pulse one cycle", int'(act_clr_vld), 0);
    step(1'b1, 9, 1'b0, 1'b0, 1'b0, 0, 1'b0, 0);
    chk("R3 higher delivery raises irq", int'(irq_out), 1);
    step(1'b0, 0, 1'b1, 1'b0, 1'b0, 0, 1'b0, 0);
    chk("R7 vector of winner", int'(ack_vector), 8'h49);
    idle();
    step(1'b0, 0, 1'b0, 1'b1, 1'b0, 0, 1'b0, 0); // retire 9
    idle();
    chk("R9 no reassert while service 9 equals pending 9", int'(irq_out), 0);
    step(1'b0, 0, 1'b0, 1'b1, 1'b0, 0, 1'b0, 0); // retire 3
    idle();
    chk("R9 reassert after service empties", int'(irq_out), 1);

    // R6: inactive winner gives spurious and clears
    b_active[5] = 1'b0;
    step(1'b0, 0, 1'b1, 1'b0, 1'b0, 0, 1'b0, 0);
    chk("R6 inactive winner spurious", int'(ack_vector), 8'hFF);
    chk("R6 clear pulse", int'(act_clr_vld), 1);
    chk("R6 clear idx", int'(act_clr_idx), 5);
    idle();
    chk("R6 winner left pending set", int'(irq_out), 0);

    // R10: programmed spurious vector
    step(1'b0, 0, 1'b0, 1'b0, 1'b0, 0, 1'b1, 8'h3C);
    step(1'b0, 0, 1'b1, 1'b0, 1'b0, 0, 1'b0, 0);
    chk("R10 programmed spurious", int'(ack_vector), 8'h3C);

    // R7: level source, no clear pulse
    b_level[1] = 1'b1;
    step(1'b1, 1, 1'b0, 1'b0, 1'b0, 0, 1'b0, 0);
    step(1'b0, 0, 1'b1, 1'b0, 1'b0, 0, 1'b0, 0);
    chk("R7 level vector", int'(ack_vector), 8'h41);
    chk("R7 level no clear", int'(act_clr_vld), 0);
    step(1'b0, 0, 1'b0, 1'b1, 1'b0, 0, 1'b0, 0);
    idle();

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      int op, idx, r;
      op  = int'($urandom_range(0, 99));
      idx = int'($urandom_range(0, NS-1));
      if ($urandom_range(0, 9) == 0) b_prio[idx] = PW'($urandom_range(0, 31));
      if ($urandom_range(0, 9) == 0) b_level[idx] = $urandom_range(0, 1) == 1;
      if ($urandom_range(0, 14) == 0) b_active[int'($urandom_range(0, NS-1))] = $urandom_range(0, 1) == 1;
      r = int'($urandom_range(0, 255));
      if (op < 40) begin
        b_active[idx] = 1'b1;
        step(1'b1, idx, 1'b0, 1'b0, 1'b0, 0, 1'b0, 0);
      end else if (op < 60) begin
        step(1'b1, idx, 1'b1, 1'b0, 1'b0, 0, 1'b0, 0);
      end else if (op < 78) begin
        step(1'b1, idx, 1'b0, 1'b1, 1'b0, 0, 1'b0, 0);
      end else if (op < 84) begin
        step(1'b0, 0, 1'b0, 1'b0, 1'b1, r, 1'b0, 0);
      end else if (op < 87) begin
        step(1'b0, 0, 1'b0, 1'b0, 1'b0, 0, 1'b1, r);
      end else begin
        idle();
      end
    end

    finish_run();
  end

endmodule